// File: doc/BRIEF.md
# Spreading-Code First-Chips Capture Register

This block runs the two 10-stage feedback shift registers of a GPS C/A Gold-code generator for a selected satellite. It takes a snapshot of the first twelve chips the generator emits after an arming event. Arming comes from any of three one-cycle strobes: a finished code slew, a finished preset sequence, or the release of the channel reset. Arming restarts both shift registers at the start of the code epoch and begins a new capture.

The generator advances on a half-chip enable, so one chip spans two enable pulses. Twelve chips therefore take 24 enables. Until then the readable snapshot keeps its old contents. When the last chip arrives, the chips are packed into a 12-bit field in a fixed, non-linear bit order. The mode that was active at arming is placed beside the field. In early-minus-late mode the snapshot holds a code-sign sequence in place of the raw chips.

A test host reads the snapshot through a strobed 16-bit port. It compares the result against known per-satellite patterns to check the code generator.

Top module: `cfc_first_chips`

## Requirements
- R1: The value p on `prn_i` (0..31) selects satellite p+1. Each chip is G1 stage 10 XOR (G2 stage a XOR G2 stage b), using the standard C/A tap pair (a,b) for that satellite: (2,6) for satellite 1, (3,7) for satellite 2, and so on. G1 feeds back stages 3 and 10. G2 feeds back stages 2,3,6,8,9,10. In early/late mode, satellite 1 reads 0x0F20 and satellite 2 reads 0x0F90.
- R2: The generator advances one chip per two `code_en_i` pulses. With no enable pulses, no chip advances and no capture completes.
- R3: A one-cycle pulse on any of `slew_done_i`, `preset_done_i` or `chan_rel_i` arms a capture. Arming restarts both shift registers at all ones and latches `prn_i` and `mode_i`. An enable in the arming cycle is ignored.
- R4: The snapshot updates on the 24th enable pulse after arming, and not before.
- R5: Packing: chip 1 is in bit 9 and chip 10 in bit 0 (chips 1..10 fill bits 9 down to 0). Chip 11 is in bit 11 and chip 12 in bit 10.
- R6: Bit 12 holds the `mode_i` value latched at arming (0 early/late, 1 early-minus-late). Bits 15..13 read 0.
- R7: In early-minus-late mode, captured value k is chip k XOR chip k-1, with chip 0 taken as 0.
- R8: `rd_en_i` loads `rd_data_o` at the next clock edge with the current snapshot. Otherwise `rd_data_o` holds.
- R9: A read issued before the capture completes, including in the completing cycle itself, returns the previous snapshot.
- R10: Arming during a capture discards the partial capture and starts a new one.
- R11: After reset, `rd_data_o` and the snapshot are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_en_i | input | 1 | Half-chip code clock enable |
| prn_i | input | 5 | Satellite select, value+1 = satellite number |
| mode_i | input | 1 | 0 early/late, 1 early-minus-late |
| slew_done_i | input | 1 | Arming strobe: slew finished |
| preset_done_i | input | 1 | Arming strobe: preset finished |
| chan_rel_i | input | 1 | Arming strobe: channel reset released |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Read data |

## Verification
A read strobe can land in the same cycle as the 24th enable that completes a capture. A new arming strobe can land in the same cycle as an enable, or in the middle of a running capture. The bench raises the read strobe on the completing edge and expects the old snapshot, then expects the new value on the read that follows. It also holds the enable high through an arming pulse and expects the pattern of the newly selected satellite, aligned to the epoch start.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int unsigned LFSR_W = 10;
  localparam int unsigned PRN_W  = 5;
  localparam logic [LFSR_W-1:0] G1_FB = 10'h204; // stages 3,10
  localparam logic [LFSR_W-1:0] G2_FB = 10'h3A6; // stages 2,3,6,8,9,10

  typedef struct packed {
    logic [3:0] a;
    logic [3:0] b;
  } g2_taps_t;

  function automatic g2_taps_t sel_taps(input logic [PRN_W-1:0] sel);
    g2_taps_t t;
    unique case (sel)
      5'd0:  t = '{4'd2, 4'd6};
      5'd1:  t = '{4'd3, 4'd7};
      5'd2:  t = '{4'd4, 4'd8};
      5'd3:  t = '{4'd5, 4'd9};
      5'd4:  t = '{4'd1, 4'd9};
      5'd5:  t = '{4'd2, 4'd10};
      5'd6:  t = '{4'd1, 4'd8};
      5'd7:  t = '{4'd2, 4'd9};
      5'd8:  t = '{4'd3, 4'd10};
      5'd9:  t = '{4'd2, 4'd3};
      5'd10: t = '{4'd3, 4'd4};
      5'd11: t = '{4'd5, 4'd6};
      5'd12: t = '{4'd6, 4'd7};
      5'd13: t = '{4'd7, 4'd8};
      5'd14: t = '{4'd8, 4'd9};
      5'd15: t = '{4'd9, 4'd10};
      5'd16: t = '{4'd1, 4'd4};
      5'd17: t = '{4'd2, 4'd5};
      5'd18: t = '{4'd3, 4'd6};
      5'd19: t = '{4'd4, 4'd7};
      5'd20: t = '{4'd5, 4'd8};
      5'd21: t = '{4'd6, 4'd9};
      5'd22: t = '{4'd1, 4'd3};
      5'd23: t = '{4'd4, 4'd6};
      5'd24: t = '{4'd5, 4'd7};
      5'd25: t = '{4'd6, 4'd8};
      5'd26: t = '{4'd7, 4'd9};
      5'd27: t = '{4'd8, 4'd10};
      5'd28: t = '{4'd1, 4'd6};
      5'd29: t = '{4'd2, 4'd7};
      5'd30: t = '{4'd3, 4'd8};
      default: t = '{4'd4, 4'd9};
    endcase
    return t;
  endfunction
endpackage

// File: rtl/cfc_lfsr.sv
module cfc_lfsr #(
  parameter int unsigned W = 10,
  parameter logic [W-1:0] FB_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb = ^(q & FB_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '1;
    else if (load_i)  q <= '1;
    else if (step_i)  q <= {q[W-2:0], fb};
  end

  assign state_o = q;
endmodule

// File: rtl/cfc_chip_gen.sv
module cfc_chip_gen
  import cfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              step_i,
  input  logic [PRN_W-1:0]  prn_i,
  output logic              chip_o,
  output logic [LFSR_W-1:0] g1_o,
  output logic [LFSR_W-1:0] g2_o
);
  logic [PRN_W-1:0] prn_q;
  g2_taps_t         taps;
  logic [3:0]       ia, ib;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prn_q <= '0;
    else if (arm_i)  prn_q <= prn_i;
  end

  cfc_lfsr #(.W(LFSR_W), .FB_MASK(G1_FB)) u_g1 (
    .clk_i, .rst_ni, .load_i(arm_i), .step_i, .state_o(g1_o)
  );

  cfc_lfsr #(.W(LFSR_W), .FB_MASK(G2_FB)) u_g2 (
    .clk_i, .rst_ni, .load_i(arm_i), .step_i, .state_o(g2_o)
  );

  always_comb begin
    taps = sel_taps(prn_q);
    ia   = taps.a - 4'd1;
    ib   = taps.b - 4'd1;
  end

  assign chip_o = g1_o[LFSR_W-1] ^ g2_o[ia] ^ g2_o[ib];
endmodule

// File: rtl/cfc_capture.sv
module cfc_capture #(
  parameter int unsigned CHIPS = 12,
  parameter int unsigned HALF  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             chip_i,
  output logic             step_o,
  output logic             done_o,
  output logic [CHIPS-1:0] vis_o,
  output logic             vis_mode_o
);
  localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned CW = $clog2(CHIPS + 1);

  logic [HW-1:0]    half_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, late_q, mode_q, vmode_q;
  logic [CHIPS-1:0] shd_q, shd_nxt, vis_q, packed_nxt;
  logic             sample;

  assign sample  = mode_q ? (chip_i ^ late_q) : chip_i;
  assign shd_nxt = {shd_q[CHIPS-2:0], sample};
  assign step_o  = en_i & ~arm_i & (half_q == HW'(HALF - 1));
  assign done_o  = busy_q & step_o & (cnt_q == CW'(CHIPS - 1));

  // oldest chip lands in the top of the low field; last two swap into the top bits
  for (genvar i = 0; i < CHIPS - 2; i++) begin : g_pack
    assign packed_nxt[i] = shd_nxt[i+2];
  end
  assign packed_nxt[CHIPS-1] = shd_nxt[1];
  assign packed_nxt[CHIPS-2] = shd_nxt[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      late_q  <= 1'b0;
      mode_q  <= 1'b0;
      shd_q   <= '0;
      vis_q   <= '0;
      vmode_q <= 1'b0;
    end else if (arm_i) begin
      half_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      late_q  <= 1'b0;
      mode_q  <= mode_i;
    end else if (en_i) begin
      half_q <= (half_q == HW'(HALF - 1)) ? '0 : half_q + 1'b1;
      if (step_o) begin
        late_q <= chip_i;
        if (busy_q) begin
          shd_q <= shd_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (done_o) begin
            busy_q  <= 1'b0;
            vis_q   <= packed_nxt;
            vmode_q <= mode_q;
          end
        end
      end
    end
  end

  assign vis_o      = vis_q;
  assign vis_mode_o = vmode_q;
endmodule

// File: rtl/cfc_first_chips.sv
module cfc_first_chips
  import cfc_pkg::*;
#(
  parameter int unsigned CHIPS = 12,
  parameter int unsigned HALF  = 2,
  parameter int unsigned RD_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             code_en_i,
  input  logic [PRN_W-1:0] prn_i,
  input  logic             mode_i,
  input  logic             slew_done_i,
  input  logic             preset_done_i,
  input  logic             chan_rel_i,
  input  logic             rd_en_i,
  output logic [RD_W-1:0]  rd_data_o
);
  localparam int unsigned PAD = RD_W - CHIPS - 1;

  logic              arm, step, done, chip, vis_mode;
  logic [CHIPS-1:0]  vis;
  logic [LFSR_W-1:0] g1, g2;
  logic [RD_W-1:0]   rd_q;

  assign arm = slew_done_i | preset_done_i | chan_rel_i;

  cfc_chip_gen u_gen (
    .clk_i, .rst_ni, .arm_i(arm), .step_i(step), .prn_i,
    .chip_o(chip), .g1_o(g1), .g2_o(g2)
  );

  cfc_capture #(.CHIPS(CHIPS), .HALF(HALF)) u_cap (
    .clk_i, .rst_ni, .arm_i(arm), .en_i(code_en_i), .mode_i, .chip_i(chip),
    .step_o(step), .done_o(done), .vis_o(vis), .vis_mode_o(vis_mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_q <= '0;
    else if (rd_en_i)  rd_q <= {{PAD{1'b0}}, vis_mode, vis};
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/cfc_first_chips_chk.sv
module cfc_first_chips_chk #(
  parameter int unsigned CHIPS = 12,
  parameter int unsigned RD_W  = 16,
  parameter int unsigned LW    = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             code_en_i,
  input logic             rd_en_i,
  input logic             arm,
  input logic             done,
  input logic             vis_mode,
  input logic [CHIPS-1:0] vis,
  input logic [LW-1:0]    g1,
  input logic [LW-1:0]    g2,
  input logic [RD_W-1:0]  rd_data_o
);
  logic [CHIPS:0] word;
  assign word = {vis_mode, vis};

  AST_RESTART_G1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> (g1 == '1)); // R3
  AST_RESTART_G2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> (g2 == '1)); // R3
  AST_NO_EN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!code_en_i && !arm) |=> ($stable(g1) && $stable(g2))); // R2
  AST_SNAP_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(word)); // R9
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R8
  AST_READ_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_data_o[CHIPS:0] == $past(word))); // R8
  AST_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[RD_W-1:CHIPS+1] == '0); // R6
endmodule

bind cfc_first_chips cfc_first_chips_chk #(
  .CHIPS(CHIPS), .RD_W(RD_W), .LW(cfc_pkg::LFSR_W)
) u_chk (
  .clk_i, .rst_ni, .code_en_i, .rd_en_i, .arm, .done, .vis_mode, .vis,
  .g1, .g2, .rd_data_o
);

// File: tb/sim_cfc_first_chips.sv
module sim_cfc_first_chips;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        code_en_i = 1'b0;
  logic [4:0]  prn_i = '0;
  logic        mode_i = 1'b0;
  logic        slew_done_i = 1'b0, preset_done_i = 1'b0, chan_rel_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [15:0] rd_data_o;

  int n_chk = 0, n_bad = 0;

  // early/late patterns for satellites 1..21
  localparam logic [11:0] EL_TBL [21] = '{
    12'hF20, 12'hF90, 12'hFC8, 12'hFE4, 12'h25B, 12'h32D, 12'hE59,
    12'h72C, 12'hB96, 12'hB44, 12'hFA2, 12'h7E8, 12'hBF4, 12'hFFA,
    12'hFFD, 12'h7FE, 12'h26E, 12'hB37, 12'h79B, 12'h3CD, 12'h3E6};

  always #4 clk_i = ~clk_i;

  cfc_first_chips u0 (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %04h expected %04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] el_word(input int sat);
    return {4'b0000, EL_TBL[sat-1]};
  endfunction

  function automatic logic [15:0] eml_word(input int sat);
    logic [11:0] v, o;
    logic c [13];
    v = EL_TBL[sat-1];
    c[0] = 1'b0;
    for (int k = 1; k <= 10; k++) c[k] = v[10-k];
    c[11] = v[11];
    c[12] = v[10];
    for (int k = 1; k <= 10; k++) o[10-k] = c[k] ^ c[k-1];
    o[11] = c[11] ^ c[10];
    o[10] = c[12] ^ c[11];
    return {3'b000, 1'b1, o};
  endfunction

  // all tasks start and end just after a falling edge
  task automatic arm(input int kind, input int sat, input bit md, input bit en);
    prn_i = 5'(sat - 1);
    mode_i = md;
    code_en_i = en;
    case (kind % 3)
      0: slew_done_i = 1'b1;
      1: preset_done_i = 1'b1;
      default: chan_rel_i = 1'b1;
    endcase
    @(negedge clk_i);
    slew_done_i = 1'b0; preset_done_i = 1'b0; chan_rel_i = 1'b0;
    code_en_i = 1'b0;
  endtask

  task automatic run_en(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      code_en_i = 1'b1;
      @(negedge clk_i);
      code_en_i = 1'b0;
      if (gaps) @(negedge clk_i);
    end
  endtask

  task automatic do_read(output logic [15:0] v);
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    v = rd_data_o;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk_i);
    check("R11 reset", rd_data_o, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_read(v);
    check("R11 first read", v, 16'h0000);

    // vector walk: R1 R3 R5, strobe kind and enable spacing rotated
    for (int s = 1; s <= 21; s++) begin
      arm(s, s, 1'b0, 1'b0);
      run_en(24, s[0]);
      do_read(v);
      check("R1/R5 pattern", v, el_word(s));
    end

    // R7 R6 early-minus-late
    for (int s = 1; s <= 4; s++) begin
      arm(s, s, 1'b1, 1'b0);
      run_en(24, 1'b0);
      do_read(v);
      check("R7 eml pattern", v, eml_word(s));
    end

    // R6 mode latched at arming
    arm(0, 6, 1'b1, 1'b0);
    mode_i = 1'b0;
    run_en(24, 1'b0);
    do_read(v);
    check("R6 mode latched", v, eml_word(6));

    // R4 R9 boundary: 23 enables not enough
    arm(1, 2, 1'b0, 1'b0);
    run_en(23, 1'b0);
    do_read(v);
    check("R9 early read", v, eml_word(6));
    run_en(1, 1'b0);
    do_read(v);
    check("R4 24th enable", v, el_word(2));

    // R9 read in the completing cycle
    arm(2, 3, 1'b0, 1'b0);
    run_en(23, 1'b1);
    code_en_i = 1'b1; rd_en_i = 1'b1;
    @(negedge clk_i);
    code_en_i = 1'b0; rd_en_i = 1'b0;
    check("R9 same-cycle read", rd_data_o, el_word(2));
    do_read(v);
    check("R9 next read", v, el_word(3));

    // R10 R3 re-arm mid-capture, enable held during arm
    arm(0, 4, 1'b0, 1'b0);
    run_en(10, 1'b0);
    arm(1, 5, 1'b0, 1'b1);
    run_en(24, 1'b0);
    do_read(v);
    check("R10 restart", v, el_word(5));

    // R2 no enables: nothing completes
    arm(2, 7, 1'b0, 1'b0);
    repeat (40) @(negedge clk_i);
    do_read(v);
    check("R2 no enable", v, el_word(5));
    run_en(24, 1'b0);
    do_read(v);
    check("R2 resumed", v, el_word(7));

    // R8 output holds without strobe
    repeat (5) @(negedge clk_i);
    check("R8 hold", rd_data_o, el_word(7));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule